// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Parity

This block turns a serial bit stream, one bit per fast-clock cycle, into 16-bit parallel words. A free-running position counter sets the word boundaries: sixteen consecutive bits make one word. The first bit of a word period lands in the least significant output bit and the last bit lands in the most significant one. There is no frame search. The first word boundary falls sixteen cycles after reset is released.

Each finished word goes to a registered output together with an even-parity bit, which is the XOR of the word as emitted. A one-cycle strobe marks the cycle in which a new word appears. An invert control complements the data on its way through. The block also drives a word clock at one sixteenth of the bit rate, with eight cycles high and eight low. It rises together with each word update, so its falling edge lands in the middle of the stable data window. A downstream register can therefore capture the word and the parity bit on that falling edge.

Top module: `bitstream_deser`

## Requirements
- R1: The word clock is 0 while reset is held. After the k-th rising clock edge that follows reset release, it equals 1 when (k mod 16) < 8 and 0 otherwise.
- R2: Counting from reset release, the bit sampled on edge k (k = 1, 2, …) belongs to word number floor((k-1)/16) and is placed at output bit position (k-1) mod 16. Bit 0 holds the earliest bit and bit 15 the latest.
- R3: The word output and the parity output change only on edges where k is a multiple of 16, and both change on the same edge. They hold their values for the 16 cycles in between.
- R4: A bit is stored complemented when the invert input is 1 on the edge at which that bit is sampled, and unchanged when it is 0. Keeping the invert input at 0 gives plain pass-through.
- R5: The parity output always equals the XOR of all 16 bits of the word output.
- R6: The word-valid output is 1 for exactly the one cycle that follows each word update and is 0 at all other times.
- R7: The word clock falls 8 cycles after each word update, and the word output does not change on that falling edge.
- R8: A synchronous reset clears the word, the parity, the valid strobe and the word clock, and it throws away any partly collected bits. A reset asserted in the middle of a word restarts the count at position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_bit_i | input | 1 | Serial data bit, sampled on each rising edge |
| invert_i | input | 1 | 1 = complement incoming bits, 0 = pass-through |
| word_o | output | 16 | Registered parallel word, bit 0 = earliest bit |
| parity_o | output | 1 | XOR of all bits of word_o |
| wclk_o | output | 1 | Divide-by-16 word clock, 8 high / 8 low |
| word_valid_o | output | 1 | One-cycle strobe in the cycle a new word appears |

## Verification
The assertions assume that reset is held from time zero until at least one rising edge has passed. They also assume that the serial bit and the invert control are settled before each rising edge, so that every sampled bit is a clean 0 or 1. The bench holds reset for several cycles at the start and changes all inputs only on the falling clock edge. It draws the random bits and invert values from a seeded generator. It also toggles the invert control in the middle of a word and asserts reset in the middle of a word, which exercises the per-bit inversion and the restart of the position count.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int unsigned DFLT_WORD_W = 16;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

endpackage

// File: rtl/deser_divider.sv
module deser_divider #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             last_o,
    output logic             wclk_o
);
    import deser_pkg::*;

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        lvl_e             wclk;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_C) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.wclk = (st_d.cnt < HALF_C) ? LVL_HIGH : LVL_LOW;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{cnt: '0, wclk: LVL_LOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.cnt;
    assign last_o = (st_q.cnt == LAST_C);
    assign wclk_o = (st_q.wclk == LVL_HIGH);

    // R1
    wclk_fall_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(wclk_o) |-> (st_q.cnt == HALF_C));

endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bit_i,
    input  logic              inv_i,
    input  logic [CNT_W-1:0]  pos_i,
    output logic [WORD_W-1:0] word_next_o
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.acc[pos_i] = bit_i ^ inv_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign word_next_o = st_d.acc;

endmodule

// File: rtl/deser_outreg.sv
module deser_outreg #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              par_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              par;
        logic              valid;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = load_i;
        if (load_i) begin
            st_d.word = word_i;
            st_d.par  = ^word_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{word: '0, par: 1'b0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign par_o   = st_q.par;
    assign valid_o = st_q.valid;

    // R3
    word_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> ($stable(word_o) && $stable(par_o)));

endmodule

// File: rtl/bitstream_deser.sv
module bitstream_deser #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_bit_i,
    input  logic              invert_i,
    output logic [WORD_W-1:0] word_o,
    output logic              parity_o,
    output logic              wclk_o,
    output logic              word_valid_o
);
    logic [CNT_W-1:0]  pos_w;
    logic              last_w;
    logic [WORD_W-1:0] asm_w;

    deser_divider #(.WORD_W(WORD_W)) div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pos_o  (pos_w),
        .last_o (last_w),
        .wclk_o (wclk_o)
    );

    deser_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_i       (ser_bit_i),
        .inv_i       (invert_i),
        .pos_i       (pos_w),
        .word_next_o (asm_w)
    );

    deser_outreg #(.WORD_W(WORD_W)) out_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (last_w),
        .word_i  (asm_w),
        .word_o  (word_o),
        .par_o   (parity_o),
        .valid_o (word_valid_o)
    );

    // R6
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        word_valid_o |=> !word_valid_o);

    // R1
    valid_wclk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        word_valid_o |-> $rose(wclk_o));

    // R5
    parity_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        parity_o == ^word_o);

    // R7
    fall_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(wclk_o) |-> $stable(word_o));

endmodule

// File: tb/bitstream_deser_tb.sv
`timescale 1ns/1ps
module bitstream_deser_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_bit = 1'b0;
    logic         inv = 1'b0;
    logic [W-1:0] word;
    logic         parity;
    logic         wclk;
    logic         valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] acc, exp_word, prev_word;
    logic         exp_par, exp_valid, exp_wclk, prev_wclk;
    int           pos;
    string        cur_tag = "R2";

    always #4 clk = ~clk;

    bitstream_deser #(.WORD_W(W)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .ser_bit_i    (ser_bit),
        .invert_i     (inv),
        .word_o       (word),
        .parity_o     (parity),
        .wclk_o       (wclk),
        .word_valid_o (valid)
    );

    function automatic logic xor_all(logic [W-1:0] v);
        logic r = 1'b0;
        for (int i = 0; i < W; i++) r = r ^ v[i];
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(word == exp_word, cur_tag, 32'(word), 32'(exp_word));
        chk(parity == exp_par, "R5", 32'(parity), 32'(exp_par));
        chk(valid == exp_valid, "R6", 32'(valid), 32'(exp_valid));
        chk(wclk == exp_wclk, "R1", 32'(wclk), 32'(exp_wclk));
        if (prev_wclk && !wclk)
            chk(word == prev_word, "R7", 32'(word), 32'(prev_word));
        prev_wclk = wclk;
        prev_word = word;
    endtask

    // called at a falling edge: drive, predict the next rising edge, then check
    task automatic step(logic b, logic iv);
        ser_bit = b;
        inv     = iv;
        acc[pos] = b ^ iv;
        if (pos == W - 1) begin
            exp_word  = acc;
            exp_par   = xor_all(acc);
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
        pos      = (pos + 1) % W;
        exp_wclk = (pos < W / 2);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset clears every output
        chk(word == '0, "R8", 32'(word), 0);
        chk(parity == 1'b0, "R8", 32'(parity), 0);
        chk(valid == 1'b0, "R8", 32'(valid), 0);
        chk(wclk == 1'b0, "R8", 32'(wclk), 0);
        acc = '0; exp_word = '0; exp_par = 1'b0; exp_valid = 1'b0; exp_wclk = 1'b0;
        prev_wclk = 1'b0; prev_word = '0;
        pos = 0;
        rst = 1'b0;
    endtask

    task automatic word_pattern(logic [W-1:0] v, logic iv);
        for (int i = 0; i < W; i++) step(v[i], iv);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        cur_tag = "R2";
        word_pattern(16'h0000, 1'b0);
        word_pattern(16'hFFFF, 1'b0);
        word_pattern(16'h0001, 1'b0);   // first bit only -> bit 0
        word_pattern(16'h8000, 1'b0);   // last bit only -> bit 15
        word_pattern(16'hA5C3, 1'b0);

        cur_tag = "R4";
        word_pattern(16'h0000, 1'b1);
        word_pattern(16'h1234, 1'b1);
        for (int i = 0; i < W; i++) step(1'b0, (i >= 8) ? 1'b1 : 1'b0);

        // R8: reset part way through a word drops the partial bits
        cur_tag = "R8";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        do_reset();
        word_pattern(16'h00F0, 1'b0);

        cur_tag = "R3";
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < W; i++)
                step(1'($urandom % 2), ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule